// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes handed over by a processor into an asynchronous serial bit stream. It keeps one waiting byte in a holding buffer and a separate frame shift register, so software can queue the next character while the current one is still going out on the line. The bit rate comes from a single-cycle transmit tick that an external divider produces. The block itself only counts these ticks.

The character format is taken from a small set of configuration inputs: the data length (5 to 8 bits), whether a parity bit is present and whether it is odd or even, and one or two stop bits. A waiting character is moved into the shift register only when the transmit-enable input is 1 and the active-low clear-to-send input is low. A frame that has already started always runs to its end. Two flags report state: `tx_rdy` shows that the holding buffer can take a byte, and `tx_empty` shows that no frame is being shifted.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset, and whenever no frame is being shifted, `txd` is 1 and `tx_empty` is 1. With `tx_en`=1 and `cts_n`=0, `tx_rdy` is 1 after reset.
- R2: A frame is one low start bit followed by the data bits, least significant bit first. The data length is 5 + `char_len`, so code 00 gives 5 bits and code 11 gives 8 bits.
- R3: When `par_en`=1, one parity bit follows the data. With `par_odd`=0 the data and parity bits together hold an even number of ones. With `par_odd`=1 they hold an odd number. When `par_en`=0 there is no parity bit.
- R4: The frame ends with one high stop bit when `two_stop`=0 and with two high stop bits when `two_stop`=1.
- R5: `tx_rdy` is 1 only when the holding buffer is empty, `tx_en`=1 and `cts_n`=0. In the cycle after a `wr_en` pulse, `tx_rdy` is 0.
- R6: `tx_empty` is 0 from the cycle after a character enters the shift register until the clock edge that ends its last stop bit.
- R7: While `cts_n`=1 or `tx_en`=0, no new frame starts: `txd` stays 1 and the buffered byte is kept. Once both conditions allow it, the byte is sent unchanged.
- R8: If `cts_n` goes high during a frame, that frame still completes with the correct bits.
- R9: A byte that is buffered while a frame is being shifted starts its start bit at the tick that ends the last stop bit of the previous frame, with no idle bit between the two frames.
- R10: `txd` changes only at clock edges where `tick`=1, so each bit lasts exactly one tick interval. A new frame starts only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle bit-time strobe |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| char_len | input | 2 | Data length code: length = 5 + code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial data line, idles high |
| tx_rdy | output | 1 | Holding buffer can take a byte |
| tx_empty | output | 1 | No frame is being shifted |

## Verification
The hardest case to reach is the handover at the end of a frame. Here the last stop bit ends on the same tick that loads the buffered byte, so the two frames must run back to back with no idle bit between them. To get there, a concurrent process watches `tx_rdy` and writes the second byte as soon as the first one has left the buffer. Meanwhile the bench's serial sampler is still decoding the first frame, and it then measures the gap before the second start bit. Another case is a clear-to-send drop in the middle of a frame. It is produced by raising `cts_n` right after the sampler has confirmed the start bit.

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                wr_en,
  input  logic [MAX_BITS-1:0] wr_data,
  input  logic                tx_en,
  input  logic                cts_n,
  input  logic [LEN_W-1:0]    char_len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  output logic                txd,
  output logic                tx_rdy,
  output logic                tx_empty
);

  localparam int FW      = MAX_BITS + 4;
  localparam int CW      = $clog2(FW + 1);
  localparam int MIN_LEN = MAX_BITS - (1 << LEN_W) + 1;

  logic [MAX_BITS-1:0] hold_q;
  logic                hold_full;
  logic [FW-1:0]       sr_q;
  logic [CW-1:0]       left_q;
  logic                busy;
  logic [FW-1:0]       frame_d;
  logic [CW-1:0]       last_d;
  logic                go, load;

  assign go       = tx_en && !cts_n;
  assign load     = tick && go && hold_full && (!busy || left_q == '0);
  assign txd      = sr_q[0];
  assign tx_rdy   = !hold_full && go;
  assign tx_empty = !busy;

  always_comb begin
    int  nd;
    logic p;
    nd = MIN_LEN + int'(char_len);
    p  = par_odd;
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < nd) begin
        frame_d[i+1] = hold_q[i];
        p = p ^ hold_q[i];
      end
    end
    for (int j = 0; j < FW; j++)
      if (par_en && j == nd + 1) frame_d[j] = p;
    last_d = CW'(nd + 1 + int'(par_en) + int'(two_stop));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sr_q      <= '1;
      left_q    <= '0;
      busy      <= 1'b0;
    end else begin
      if (tick && busy) begin
        if (left_q == '0) begin
          busy <= 1'b0;
        end else begin
          sr_q   <= {1'b1, sr_q[FW-1:1]};
          left_q <= left_q - 1'b1;
        end
      end
      if (load) begin
        sr_q   <= frame_d;
        left_q <= last_d;
        busy   <= 1'b1;
      end
      if (wr_en) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
    end
  end

endmodule

module serial_tx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic wr_en,
  input logic tx_en,
  input logic cts_n,
  input logic txd,
  input logic tx_rdy,
  input logic tx_empty
);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);

  a_r5_write_fills: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_rdy);

  a_r7_no_start_blocked: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && (cts_n || !tx_en)) |=> tx_empty);

  a_r8_frame_holds: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty && !tick) |=> !tx_empty);

  a_r10_bit_timing: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));

endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .tx_en(tx_en),
  .cts_n(cts_n), .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
);

// File: tb/tb_serial_tx_dbuf.sv
module tb_serial_tx_dbuf;

  logic       clk = 0, rst = 1, tick = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       tx_en = 1, cts_n = 0;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 0, par_odd = 0, two_stop = 0;
  logic       txd, tx_rdy, tx_empty;
  int         n_chk = 0, n_bad = 0, ph = 0;

  serial_tx_dbuf dut (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ph   <= (ph + 1) % 4;
    tick <= (ph == 2);
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [7:0] d, output logic [11:0] f, output int n);
    int  nd, idx;
    logic p;
    nd = 5 + int'(char_len);
    f = '1; f[0] = 1'b0; p = par_odd;
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      p = p ^ d[i];
    end
    idx = nd + 1;
    if (par_en) begin
      f[idx] = p;
      idx++;
    end
    n = idx + 1 + int'(two_stop);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic recv(input int n, output logic [11:0] bits, output int waited);
    bits = '1; waited = 0;
    while (txd !== 1'b0 && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (4) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic t_reset;
    check(txd === 1'b1, "R1 txd idle", int'(txd), 1);
    check(tx_empty === 1'b1, "R1 tx_empty", int'(tx_empty), 1);
    check(tx_rdy === 1'b1, "R1 tx_rdy", int'(tx_rdy), 1);
  endtask

  task automatic t_frame(input logic [7:0] d, input logic [1:0] len, input bit pe,
                         input bit po, input bit ts, input string tag);
    logic [11:0] exp_f, got;
    int n, w;
    char_len = len; par_en = pe; par_odd = po; two_stop = ts;
    build(d, exp_f, n);
    write(d);
    check(tx_rdy === 1'b0, {tag, " R5 rdy after write"}, int'(tx_rdy), 0);
    recv(n, got, w);
    check(got === exp_f, {tag, " R2 R3 R4 R10 frame bits"}, int'(got), int'(exp_f));
    repeat (3) @(negedge clk);
    check(tx_empty === 1'b1 && txd === 1'b1, {tag, " R6 R1 idle after"}, int'({tx_empty, txd}), 3);
  endtask

  task automatic t_flags;
    write(8'h3C);
    while (tx_empty === 1'b1) @(negedge clk);
    check(tx_rdy === 1'b1, "R5 rdy after transfer", int'(tx_rdy), 1);
    check(txd === 1'b0, "R6 start with tx_empty low", int'(txd), 0);
    cts_n = 1;
    @(negedge clk);
    check(tx_rdy === 1'b0, "R5 rdy gated by cts", int'(tx_rdy), 0);
    cts_n = 0;
    repeat (50) @(negedge clk);
    check(tx_empty === 1'b1, "R6 empty after frame", int'(tx_empty), 1);
  endtask

  task automatic t_blocked(input bit use_cts);
    logic [11:0] exp_f, got;
    int n, w;
    bit stayed;
    char_len = 2'd3; par_en = 1; par_odd = 0; two_stop = 0;
    if (use_cts) cts_n = 1; else tx_en = 0;
    write(8'h96);
    stayed = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_empty !== 1'b1) stayed = 0;
    end
    check(stayed, "R7 no start while blocked", int'(stayed), 1);
    check(tx_rdy === 1'b0, "R5 rdy low while blocked", int'(tx_rdy), 0);
    build(8'h96, exp_f, n);
    cts_n = 0; tx_en = 1;
    recv(n, got, w);
    check(got === exp_f, "R7 kept byte sent", int'(got), int'(exp_f));
    repeat (3) @(negedge clk);
  endtask

  task automatic t_midcts;
    logic [11:0] exp_f, got;
    int n;
    char_len = 2'd3; par_en = 0; two_stop = 1;
    build(8'hC3, exp_f, n);
    write(8'hC3);
    while (txd !== 1'b0) @(negedge clk);
    @(negedge clk);
    got = '1; got[0] = txd;
    cts_n = 1;
    for (int i = 1; i < n; i++) begin
      repeat (4) @(negedge clk);
      got[i] = txd;
    end
    check(got === exp_f, "R8 frame completes after cts high", int'(got), int'(exp_f));
    repeat (3) @(negedge clk);
    check(tx_empty === 1'b1, "R8 ends with cts high", int'(tx_empty), 1);
    cts_n = 0;
  endtask

  task automatic t_b2b;
    logic [11:0] ea, eb, ga, gb;
    int n, wa, wb;
    char_len = 2'd2; par_en = 1; par_odd = 1; two_stop = 0;
    build(8'h55, ea, n);
    build(8'h2E, eb, n);
    write(8'h55);
    fork
      recv(n, ga, wa);
      begin
        while (tx_rdy !== 1'b0) @(negedge clk);
        while (tx_rdy !== 1'b1) @(negedge clk);
        write(8'h2E);
      end
    join
    recv(n, gb, wb);
    check(ga === ea, "R9 first frame", int'(ga), int'(ea));
    check(gb === eb, "R9 second frame", int'(gb), int'(eb));
    check(wb <= 3, "R9 no idle gap", wb, 3);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_frame(8'hA5, 2'd3, 0, 0, 0, "8N1");
    t_frame(8'h13, 2'd0, 1, 0, 1, "5E2");
    t_frame(8'h6B, 2'd2, 1, 1, 0, "7O1");
    t_frame(8'hF0, 2'd1, 1, 1, 1, "6O2");
    t_flags();
    t_blocked(1);
    t_blocked(0);
    t_midcts();
    t_b2b();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule